// File: doc/BRIEF.md
# PIO Cycle Clock-Count Calculator

This block turns a requested programmed-I/O transfer timing, given in nanoseconds, into the clock counts that a disk-interface timing generator needs. The counts cover the address setup, active strobe and recovery phases. A caller loads the setup time, the active time, the total cycle time and the bus clock period, then pulses `start_i`. A single shared restoring divider works out each rounded-up count in turn. A shaping stage applies the controller's legal limits and, on the older or newer silicon revision, its recovery convention. A packing stage then builds the two register bytes the timing generator decodes.

The two drives on the secondary channel share one set of timing registers. For that case the caller also supplies the partner drive's stored counts and a present flag. The register bytes then carry the slower of the two drives in each phase. The three count outputs always hold this drive's own values, so the caller can store them for later merges. When the result is ready, `done_o` pulses for one cycle and all results hold until the next completion. A zero clock period cannot be divided. It yields the slowest legal timing and raises `err_o`.

Top module: `pio_timing_calc`

## Requirements
- R1: Setup, active, recovery and whole-cycle counts are each the ceiling of the time divided by `period_ns_i`. Recovery time is the cycle time less the setup and active times, taken as 0 if negative.
- R2: Recovery is the larger of its rounded count and (cycle count − setup count − active count), with a negative difference taken as 0. The active count used here is the one after its minimum is applied.
- R3: The active count and the pre-adjust recovery count are each raised to at least 2.
- R4: If recovery exceeds 17, the excess is added to active and recovery becomes 17. Active is then limited to 16.
- R5: When `rev_b_i` is 1, one is subtracted from recovery. The recovery count is then limited to 16 for both revisions.
- R6: When `mate_present_i` is 1, each register-byte field uses the larger of this drive's count and the matching partner count. When it is 0, the partner counts have no effect. The count outputs are never merged.
- R7: `setup_byte_o[7:6]` encodes the (merged) setup count: 1 or 2 → 01, 3 → 10, 4 → 00, anything else → 11. Bits 5:0 are 0.
- R8: `timing_byte_o[7:4]` is the (merged) active count and `[3:0]` is the recovery count, with a count of 16 written as 0.
- R9: A zero `period_ns_i` gives counts 4/16/16 with `err_o` = 1. Any nonzero period gives `err_o` = 0.
- R10: `done_o` is high for exactly one cycle per accepted start, and all result outputs change only in that cycle.
- R11: A `start_i` pulse while a computation is in progress is ignored: no extra completion, and the running result is not altered.
- R12: After reset `done_o` and `err_o` are 0, the counts read 4/16/16, and both bytes read 0x00.
- R13: `setup_cnt_o` saturates at 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a calculation (accepted only when idle) |
| setup_ns_i | input | TIME_W | Address setup time, ns |
| active_ns_i | input | TIME_W | Active strobe time, ns |
| cycle_ns_i | input | TIME_W | Whole cycle time, ns |
| period_ns_i | input | PER_W | Bus clock period, ns |
| rev_b_i | input | 1 | Newer silicon that adds one recovery clock itself |
| mate_present_i | input | 1 | Partner drive on the shared channel exists |
| mate_setup_i | input | 5 | Partner setup count |
| mate_active_i | input | 5 | Partner active count |
| mate_recov_i | input | 5 | Partner recovery count |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Zero period was requested |
| setup_cnt_o | output | 5 | This drive's setup count |
| active_cnt_o | output | 5 | This drive's active count |
| recov_cnt_o | output | 5 | This drive's recovery count |
| setup_byte_o | output | 8 | Encoded setup register byte |
| timing_byte_o | output | 8 | Packed active/recovery register byte |

## Verification
A corrupted divider remainder or quotient shows up as a wrong count at the next `done_o`, about fifty cycles after the start. A sequencer that loses its operand index either stores a quotient in the wrong phase, which gives visibly swapped counts, or never completes, which shows as a missing `done_o`. Faults in the limit and merge logic show only in the corner cases: large recovery spilling into active, the revision adjustment, a partner slower in some phases but not others, and setup values outside the 1–4 range. Each of these has a directed case with precomputed bytes.

// File: rtl/pio_calc_pkg.sv
package pio_calc_pkg;

    localparam int CNT_W = 5;

    typedef logic [CNT_W-1:0] cnt_t;

    // two-bit setup field code as decoded by the timing generator
    function automatic logic [1:0] setup_code(input cnt_t s);
        logic [1:0] c;
        case (s)
            5'd1, 5'd2: c = 2'b01;
            5'd3:       c = 2'b10;
            5'd4:       c = 2'b00;
            default:    c = 2'b11;
        endcase
        return c;
    endfunction

    // a count of 16 (or more) occupies a nibble as zero
    function automatic logic [3:0] to_nibble(input cnt_t c);
        return (c >= 5'd16) ? 4'd0 : c[3:0];
    endfunction

    function automatic cnt_t cnt_max(input cnt_t a, input cnt_t b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pio_ceil_div.sv
module pio_ceil_div #(
    parameter int NUM_W = 11,
    parameter int DEN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go_i,
    input  logic [NUM_W-1:0] num_i,
    input  logic [DEN_W-1:0] den_i,
    output logic [NUM_W-1:0] quo_o,
    output logic             valid_o
);

    localparam int CW = $clog2(NUM_W + 1);

    typedef struct packed {
        logic             busy;
        logic [CW-1:0]    cnt;
        logic [DEN_W-1:0] rem;
        logic [NUM_W-1:0] quo;
        logic [DEN_W-1:0] den;
        logic             valid;
    } div_st_t;

    div_st_t st_d, st_q;
    logic [DEN_W:0] shifted;
    logic [DEN_W:0] trial;

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        shifted    = {st_q.rem, st_q.quo[NUM_W-1]};
        trial      = shifted - {1'b0, st_q.den};
        if (go_i && !st_q.busy) begin
            st_d.busy = 1'b1;
            st_d.cnt  = CW'(NUM_W);
            st_d.rem  = '0;
            st_d.quo  = num_i;
            st_d.den  = den_i;
        end else if (st_q.busy) begin
            if (!trial[DEN_W]) begin
                st_d.rem = trial[DEN_W-1:0];
                st_d.quo = {st_q.quo[NUM_W-2:0], 1'b1};
            end else begin
                st_d.rem = shifted[DEN_W-1:0];
                st_d.quo = {st_q.quo[NUM_W-2:0], 1'b0};
            end
            st_d.cnt = st_q.cnt - CW'(1);
            if (st_q.cnt == CW'(1)) begin
                st_d.busy  = 1'b0;
                st_d.valid = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign quo_o   = st_q.quo;
    assign valid_o = st_q.valid;

    AST_DIV_REM_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.valid |-> (st_q.rem < st_q.den)); // R1

    AST_DIV_NO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && st_q.cnt != CW'(1)) |=> st_q.busy); // R1

endmodule

// File: rtl/pio_count_shape.sv
module pio_count_shape
    import pio_calc_pkg::*;
#(
    parameter int NUM_W = 11
) (
    input  logic [NUM_W-1:0] q_set_i,
    input  logic [NUM_W-1:0] q_act_i,
    input  logic [NUM_W-1:0] q_rec_i,
    input  logic [NUM_W-1:0] q_cyc_i,
    input  logic             rev_b_i,
    input  logic             zero_i,
    output cnt_t             set_o,
    output cnt_t             act_o,
    output cnt_t             rec_o
);

    localparam int W = NUM_W + 2;

    logic [W-1:0] s_w, a1, cyc_w, sum_sa, left_w, rec_w;
    logic [W-1:0] r1, r2, r3, r4, r5, a2, a3;

    always_comb begin
        s_w    = W'(q_set_i);
        cyc_w  = W'(q_cyc_i);
        rec_w  = W'(q_rec_i);
        a1     = (q_act_i < NUM_W'(2)) ? W'(2) : W'(q_act_i);
        sum_sa = s_w + a1;
        left_w = (cyc_w > sum_sa) ? (cyc_w - sum_sa) : '0;
        r1     = (rec_w > left_w) ? rec_w : left_w;
        r2     = (r1 < W'(2)) ? W'(2) : r1;
        if (r2 > W'(17)) begin
            a2 = a1 + r2 - W'(17);
            r3 = W'(17);
        end else begin
            a2 = a1;
            r3 = r2;
        end
        a3 = (a2 > W'(16)) ? W'(16) : a2;
        r4 = rev_b_i ? (r3 - W'(1)) : r3;
        r5 = (r4 > W'(16)) ? W'(16) : r4;
        if (zero_i) begin
            set_o = 5'd4;
            act_o = 5'd16;
            rec_o = 5'd16;
        end else begin
            set_o = (s_w > W'(31)) ? 5'd31 : CNT_W'(s_w);
            act_o = CNT_W'(a3);
            rec_o = CNT_W'(r5);
        end
    end

endmodule

// File: rtl/pio_merge_pack.sv
module pio_merge_pack
    import pio_calc_pkg::*;
(
    input  cnt_t       own_set_i,
    input  cnt_t       own_act_i,
    input  cnt_t       own_rec_i,
    input  logic       mate_on_i,
    input  cnt_t       mate_set_i,
    input  cnt_t       mate_act_i,
    input  cnt_t       mate_rec_i,
    output logic [7:0] setup_byte_o,
    output logic [7:0] timing_byte_o
);

    cnt_t m_set, m_act, m_rec;

    always_comb begin
        if (mate_on_i) begin
            m_set = cnt_max(own_set_i, mate_set_i);
            m_act = cnt_max(own_act_i, mate_act_i);
            m_rec = cnt_max(own_rec_i, mate_rec_i);
        end else begin
            m_set = own_set_i;
            m_act = own_act_i;
            m_rec = own_rec_i;
        end
        setup_byte_o  = {setup_code(m_set), 6'b000000};
        timing_byte_o = {to_nibble(m_act), to_nibble(m_rec)};
    end

endmodule

// File: rtl/pio_timing_calc.sv
module pio_timing_calc
    import pio_calc_pkg::*;
#(
    parameter int TIME_W = 10,
    parameter int PER_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [TIME_W-1:0] setup_ns_i,
    input  logic [TIME_W-1:0] active_ns_i,
    input  logic [TIME_W-1:0] cycle_ns_i,
    input  logic [PER_W-1:0]  period_ns_i,
    input  logic              rev_b_i,
    input  logic              mate_present_i,
    input  logic [4:0]        mate_setup_i,
    input  logic [4:0]        mate_active_i,
    input  logic [4:0]        mate_recov_i,
    output logic              done_o,
    output logic              err_o,
    output logic [4:0]        setup_cnt_o,
    output logic [4:0]        active_cnt_o,
    output logic [4:0]        recov_cnt_o,
    output logic [7:0]        setup_byte_o,
    output logic [7:0]        timing_byte_o
);

    localparam int NUM_W = TIME_W + 1;
    localparam int N_OPS = 4;

    typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_FIN} phase_e;

    typedef struct packed {
        phase_e                       ph;
        logic [1:0]                   idx;
        logic [TIME_W-1:0]            sns;
        logic [TIME_W-1:0]            ans;
        logic [TIME_W-1:0]            cns;
        logic [TIME_W-1:0]            rns;
        logic [PER_W-1:0]             per;
        logic                         rev;
        logic                         zero;
        logic                         mate_on;
        cnt_t                         ms;
        cnt_t                         ma;
        cnt_t                         mr;
        logic [N_OPS-1:0][NUM_W-1:0]  qv;
        logic                         done;
        logic                         err;
        cnt_t                         so;
        cnt_t                         ao;
        cnt_t                         ro;
        logic [7:0]                   sb;
        logic [7:0]                   tb;
    } calc_st_t;

    calc_st_t st_d, st_q;

    logic              div_go, div_valid;
    logic [NUM_W-1:0]  div_num, div_quo;
    logic [TIME_W-1:0] op_ns;
    logic [NUM_W-1:0]  sum_sa;
    cnt_t              sh_set, sh_act, sh_rec;
    logic [7:0]        pk_sb, pk_tb;

    // operand selection for the shared divider: numerator is time + period - 1
    always_comb begin
        case (st_q.idx)
            2'd0:    op_ns = st_q.sns;
            2'd1:    op_ns = st_q.ans;
            2'd2:    op_ns = st_q.rns;
            default: op_ns = st_q.cns;
        endcase
        div_num = NUM_W'(op_ns) + NUM_W'(st_q.per) - NUM_W'(1);
        div_go  = (st_q.ph == S_ISSUE);
    end

    pio_ceil_div #(.NUM_W(NUM_W), .DEN_W(PER_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .go_i    (div_go),
        .num_i   (div_num),
        .den_i   (st_q.per),
        .quo_o   (div_quo),
        .valid_o (div_valid)
    );

    pio_count_shape #(.NUM_W(NUM_W)) u_shape (
        .q_set_i (st_q.qv[0]),
        .q_act_i (st_q.qv[1]),
        .q_rec_i (st_q.qv[2]),
        .q_cyc_i (st_q.qv[3]),
        .rev_b_i (st_q.rev),
        .zero_i  (st_q.zero),
        .set_o   (sh_set),
        .act_o   (sh_act),
        .rec_o   (sh_rec)
    );

    pio_merge_pack u_pack (
        .own_set_i     (sh_set),
        .own_act_i     (sh_act),
        .own_rec_i     (sh_rec),
        .mate_on_i     (st_q.mate_on),
        .mate_set_i    (st_q.ms),
        .mate_act_i    (st_q.ma),
        .mate_rec_i    (st_q.mr),
        .setup_byte_o  (pk_sb),
        .timing_byte_o (pk_tb)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        sum_sa    = NUM_W'(setup_ns_i) + NUM_W'(active_ns_i);
        case (st_q.ph)
            S_IDLE: begin
                if (start_i) begin
                    st_d.sns     = setup_ns_i;
                    st_d.ans     = active_ns_i;
                    st_d.cns     = cycle_ns_i;
                    st_d.rns     = (NUM_W'(cycle_ns_i) > sum_sa)
                                   ? TIME_W'(NUM_W'(cycle_ns_i) - sum_sa) : '0;
                    st_d.per     = period_ns_i;
                    st_d.rev     = rev_b_i;
                    st_d.zero    = (period_ns_i == '0);
                    st_d.mate_on = mate_present_i;
                    st_d.ms      = mate_setup_i;
                    st_d.ma      = mate_active_i;
                    st_d.mr      = mate_recov_i;
                    st_d.idx     = 2'd0;
                    st_d.ph      = (period_ns_i == '0) ? S_FIN : S_ISSUE;
                end
            end
            S_ISSUE: st_d.ph = S_WAIT;
            S_WAIT: begin
                if (div_valid) begin
                    st_d.qv[st_q.idx] = div_quo;
                    if (st_q.idx == 2'(N_OPS - 1)) begin
                        st_d.ph = S_FIN;
                    end else begin
                        st_d.idx = st_q.idx + 2'd1;
                        st_d.ph  = S_ISSUE;
                    end
                end
            end
            default: begin
                st_d.so   = sh_set;
                st_d.ao   = sh_act;
                st_d.ro   = sh_rec;
                st_d.sb   = pk_sb;
                st_d.tb   = pk_tb;
                st_d.err  = st_q.zero;
                st_d.done = 1'b1;
                st_d.ph   = S_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= '0;
            st_q.ph <= S_IDLE;
            st_q.so <= 5'd4;
            st_q.ao <= 5'd16;
            st_q.ro <= 5'd16;
        end else begin
            st_q <= st_d;
        end
    end

    assign done_o        = st_q.done;
    assign err_o         = st_q.err;
    assign setup_cnt_o   = st_q.so;
    assign active_cnt_o  = st_q.ao;
    assign recov_cnt_o   = st_q.ro;
    assign setup_byte_o  = st_q.sb;
    assign timing_byte_o = st_q.tb;

    AST_ACT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !err_o) |-> (active_cnt_o >= 5'd2 && active_cnt_o <= 5'd16)); // R3

    AST_REC_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !err_o) |-> (recov_cnt_o >= 5'd1 && recov_cnt_o <= 5'd16)); // R5

    AST_ZERO_SLOWEST: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && err_o) |-> (setup_cnt_o == 5'd4 && active_cnt_o == 5'd16
                               && recov_cnt_o == 5'd16)); // R9

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R10

    AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> $stable({err_o, setup_cnt_o, active_cnt_o, recov_cnt_o,
                             setup_byte_o, timing_byte_o})); // R10

    AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph != S_IDLE && start_i) |=> $stable({st_q.sns, st_q.ans, st_q.cns, st_q.per})); // R11

endmodule

// File: tb/pio_timing_calc_tb.sv
module pio_timing_calc_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [9:0] setup_ns_i = '0, active_ns_i = '0, cycle_ns_i = '0;
    logic [7:0] period_ns_i = '0;
    logic       rev_b_i = 1'b0, mate_present_i = 1'b0;
    logic [4:0] mate_setup_i = '0, mate_active_i = '0, mate_recov_i = '0;
    logic       done_o, err_o;
    logic [4:0] setup_cnt_o, active_cnt_o, recov_cnt_o;
    logic [7:0] setup_byte_o, timing_byte_o;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    pio_timing_calc u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .setup_ns_i(setup_ns_i), .active_ns_i(active_ns_i), .cycle_ns_i(cycle_ns_i),
        .period_ns_i(period_ns_i), .rev_b_i(rev_b_i), .mate_present_i(mate_present_i),
        .mate_setup_i(mate_setup_i), .mate_active_i(mate_active_i), .mate_recov_i(mate_recov_i),
        .done_o(done_o), .err_o(err_o), .setup_cnt_o(setup_cnt_o),
        .active_cnt_o(active_cnt_o), .recov_cnt_o(recov_cnt_o),
        .setup_byte_o(setup_byte_o), .timing_byte_o(timing_byte_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic apply(input int s, input int a, input int c, input int p, input bit rev,
                         input bit mon, input int ms, input int ma, input int mr);
        setup_ns_i     = 10'(s);
        active_ns_i    = 10'(a);
        cycle_ns_i     = 10'(c);
        period_ns_i    = 8'(p);
        rev_b_i        = rev;
        mate_present_i = mon;
        mate_setup_i   = 5'(ms);
        mate_active_i  = 5'(ma);
        mate_recov_i   = 5'(mr);
    endtask

    task automatic pulse_start();
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
    endtask

    task automatic wait_done(input string tag);
        bit seen = 0;
        for (int i = 0; i < 400 && !seen; i++) begin
            if (done_o) seen = 1;
            else @(negedge clk);
        end
        chk({tag, " done seen"}, int'(seen), 1);
    endtask

    task automatic expect_all(input string tag, input int s, input int a, input int r,
                              input int sb, input int tb, input int e);
        chk({tag, " setup count"}, setup_cnt_o, s);
        chk({tag, " active count"}, active_cnt_o, a);
        chk({tag, " recovery count"}, recov_cnt_o, r);
        chk({tag, " setup byte"}, setup_byte_o, sb);
        chk({tag, " timing byte"}, timing_byte_o, tb);
        chk({tag, " err"}, err_o, e);
    endtask

    task automatic run_case(input string tag, input int s, input int a, input int c,
                            input int p, input bit rev, input bit mon, input int ms,
                            input int ma, input int mr, input int es, input int ea,
                            input int er, input int esb, input int etb, input int ee);
        apply(s, a, c, p, rev, mon, ms, ma, mr);
        pulse_start();
        wait_done(tag);
        expect_all(tag, es, ea, er, esb, etb, ee);
        @(negedge clk);
        chk({tag, " R10 done one cycle"}, done_o, 0);
    endtask

    task automatic t_reset();
        expect_all("R12 reset", 4, 16, 16, 8'h00, 8'h00, 0);
        chk("R12 reset done", done_o, 0);
    endtask

    task automatic t_basic();
        run_case("R1 R2 basic", 70, 165, 600, 30, 0, 0, 0, 0, 0, 3, 6, 13, 8'h80, 8'h6D, 0);
    endtask

    task automatic t_rev();
        run_case("R5 rev adjust", 70, 165, 600, 30, 1, 0, 0, 0, 0, 3, 6, 12, 8'h80, 8'h6C, 0);
        run_case("R5 rev floor", 100, 100, 150, 30, 1, 0, 0, 0, 0, 4, 4, 1, 8'h00, 8'h41, 0);
    endtask

    task automatic t_spill();
        run_case("R4 R8 spill", 30, 30, 900, 30, 0, 0, 0, 0, 0, 1, 13, 16, 8'h40, 8'hD0, 0);
        run_case("R4 R8 active cap", 30, 300, 1000, 30, 0, 0, 0, 0, 0, 1, 16, 16, 8'h40, 8'h00, 0);
    endtask

    task automatic t_minimums();
        run_case("R2 R3 R7 negative recovery", 100, 100, 150, 30, 0, 0, 0, 0, 0,
                 4, 4, 2, 8'h00, 8'h42, 0);
    endtask

    task automatic t_encode();
        run_case("R7 setup five", 140, 60, 400, 30, 0, 0, 0, 0, 0, 5, 2, 7, 8'hC0, 8'h27, 0);
        run_case("R13 setup saturate", 100, 100, 300, 1, 0, 0, 0, 0, 0,
                 31, 16, 16, 8'hC0, 8'h00, 0);
    endtask

    task automatic t_merge();
        run_case("R6 merge present", 70, 165, 600, 30, 0, 1, 5, 10, 3,
                 3, 6, 13, 8'hC0, 8'hAD, 0);
        run_case("R6 mate absent ignored", 70, 165, 600, 30, 0, 0, 5, 10, 3,
                 3, 6, 13, 8'h80, 8'h6D, 0);
    endtask

    task automatic t_zero();
        run_case("R9 zero period", 70, 165, 600, 0, 0, 0, 0, 0, 0, 4, 16, 16, 8'h00, 8'h00, 1);
        run_case("R9 err clears", 70, 165, 600, 30, 0, 0, 0, 0, 0, 3, 6, 13, 8'h80, 8'h6D, 0);
    endtask

    task automatic t_busy();
        int extra = 0;
        apply(30, 30, 900, 30, 0, 0, 0, 0, 0);
        pulse_start();
        repeat (3) @(negedge clk);
        apply(140, 60, 400, 30, 0, 0, 0, 0, 0);
        start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        wait_done("R11 busy");
        expect_all("R11 busy result", 1, 13, 16, 8'h40, 8'hD0, 0);
        for (int i = 0; i < 150; i++) begin
            @(negedge clk);
            if (done_o) extra++;
        end
        chk("R11 no extra done", extra, 0);
        chk("R10 hold timing byte", timing_byte_o, 8'hD0);
        chk("R10 hold active", active_cnt_o, 13);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_rev();
        t_spill();
        t_minimums();
        t_encode();
        t_merge();
        t_zero();
        t_busy();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #1000000;
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule